// File: doc/BRIEF.md
# Serial DMA Data Port with Word Shifters

This block is the data path between a memory bus and a 24-bit serial audio/telephony link. Each direction has one bus-visible data register. Behind each register sits a 24-bit shift register that the bus cannot address. A word for transmission enters the transmit register in one of two ways: a DMA write, which is accepted only while transmit DMA is enabled, or a programmed-I/O write, which is always accepted. The transmit shifter takes that word at the next word boundary and sends it one bit per serial clock enable, most significant bit first. Incoming serial bits enter the receive shifter at bit 0 and move toward the top. At each word boundary the completed word is copied into the receive register, where DMA or programmed I/O can read it.

Word boundaries come from a frame strobe that is sampled only on serial-enable cycles. The strobe is raised together with the last bit of each word. At that edge the transmit shifter reloads and the receive register captures a complete word. Both loads happen on every boundary, whether or not any DMA direction is enabled. The bus is 32 bits wide and the data is 24 bits wide. The upper byte of either register always reads as zero, and the upper byte of any write is discarded.

Top module: `sdma_data_port`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the block clears both registers and both shifters to zero. After that edge, `tx_rd_data`, `rx_rd_data` and `ser_tx` all read 0.
- R2: Bits 31:24 of `tx_rd_data` and `rx_rd_data` are always zero.
- R3: A programmed-I/O write stores `pio_wr_data[23:0]` and discards bits 31:24. `pio_wr_tx` writes the transmit register and `pio_wr_rx` writes the receive register. The new value is visible after the edge.
- R4: With `dma_wr_valid` high, the transmit register loads `dma_wr_data[23:0]` only if `tx_dma_en` is 1. Otherwise it holds. When `pio_wr_tx` is high in the same cycle, the programmed-I/O data wins.
- R5: On an edge where `ser_en` and `frame` are both high, the transmit shifter loads the transmit register value held before that edge. This happens regardless of `tx_dma_en`.
- R6: `ser_tx` always shows shifter bit 23. On each edge with `ser_en` high and `frame` low, the shifter moves one place toward the MSB and fills bit 0 with zero. With `ser_en` low, `ser_tx` holds.
- R7: On each edge with `ser_en` high, the receive shifter takes `ser_rx` into bit 0 and moves its older bits up by one place.
- R8: On an edge where `ser_en` and `frame` are both high, the receive register loads {receive shifter bits 22:0, `ser_rx`}. The result is the 24 bits received up to and including this one, with the earliest bit at position 23.
- R9: If a receive-register capture and a `pio_wr_rx` write fall on the same edge, the capture wins.
- R10: A `frame` pulse while `ser_en` is low has no effect on either register or either shifter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_en | input | 1 | Serial bit enable, one bit per high cycle |
| frame | input | 1 | Word-boundary strobe, high with the last bit of a word |
| ser_rx | input | 1 | Serial receive bit |
| ser_tx | output | 1 | Serial transmit bit (transmit shifter MSB) |
| tx_dma_en | input | 1 | Transmit DMA enable |
| dma_wr_valid | input | 1 | DMA write strobe for the transmit register |
| dma_wr_data | input | 32 | DMA write data |
| pio_wr_tx | input | 1 | Programmed-I/O write to the transmit register |
| pio_wr_rx | input | 1 | Programmed-I/O write to the receive register |
| pio_wr_data | input | 32 | Programmed-I/O write data |
| tx_rd_data | output | 32 | Transmit register read value, top byte zero |
| rx_rd_data | output | 32 | Receive register read value, top byte zero |

## Verification
Both shifters are hidden, so a corrupt shifter shows up only through the serial pin or through the next captured word. A bad transmit shifter changes `ser_tx` on the first serial-enable edge after the fault. A bad receive shifter stays out of sight until the next frame capture, which can be up to 24 enabled bits later; the bench therefore loops `ser_tx` back into `ser_rx` and compares whole captured words. A register fault shows on the read outputs in the cycle after the write or capture that caused it.

// File: rtl/sdma_pkg.sv
// Shared constants and load-select types for the serial DMA data port.
// Assumes a single clock domain; no logic lives here.
package sdma_pkg;

    localparam int SDMA_BUS_W  = 32;
    localparam int SDMA_WORD_W = 24;

    // Source chosen for the transmit register on a given cycle.
    typedef enum logic [1:0] {
        TXLD_HOLD = 2'd0,
        TXLD_DMA  = 2'd1,
        TXLD_PIO  = 2'd2
    } txld_e;

    // Source chosen for the receive register on a given cycle.
    typedef enum logic [1:0] {
        RXLD_HOLD  = 2'd0,
        RXLD_PIO   = 2'd1,
        RXLD_FRAME = 2'd2
    } rxld_e;

endpackage

// File: rtl/sdma_bus_pad.sv
// Widens a data word to the bus width and fills the unused upper bits
// with zero. Assumes BUS_W >= DATA_W. Pure wiring, no state.
module sdma_bus_pad #(
    parameter int BUS_W  = 32,
    parameter int DATA_W = 24
) (
    input  logic [DATA_W-1:0] word_in,
    output logic [BUS_W-1:0]  bus_out
);

    localparam int PAD_W = BUS_W - DATA_W;

    generate
        if (PAD_W > 0) begin : g_pad
            // Zero-extend into the upper lanes.
            assign bus_out = {{PAD_W{1'b0}}, word_in};
        end else begin : g_nopad
            // Widths match; pass straight through.
            assign bus_out = word_in;
        end
    endgenerate

endmodule

// File: rtl/sdma_tx_path.sv
// Transmit side: the bus-visible transmit register and the hidden
// transmit shifter. The register takes programmed-I/O writes always,
// and DMA writes only while DMA is enabled; PIO wins a collision.
// The shifter reloads from the register on each enabled frame edge,
// whatever the DMA enable, and otherwise shifts out MSB first.
// Assumes synchronous active-low reset and DATA_W >= 2.
module sdma_tx_path
    import sdma_pkg::*;
#(
    parameter int DATA_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_en,
    input  logic              frame,
    input  logic              dma_en,
    input  logic              dma_valid,
    input  logic [DATA_W-1:0] dma_data,
    input  logic              pio_wr,
    input  logic [DATA_W-1:0] pio_data,
    output logic [DATA_W-1:0] reg_q,
    output logic              ser_out
);

    txld_e             ld_sel;
    logic [DATA_W-1:0] shift_q;
    logic              boundary;

    // A word boundary counts only on a serial-enable cycle.
    assign boundary = ser_en && frame;

    // Select the transmit register source for this cycle.
    always_comb begin
        if (pio_wr)
            ld_sel = TXLD_PIO;
        else if (dma_valid && dma_en)
            ld_sel = TXLD_DMA;
        else
            ld_sel = TXLD_HOLD;
    end

    // Transmit register update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_q <= '0;
        end else begin
            case (ld_sel)
                TXLD_PIO: reg_q <= pio_data;
                TXLD_DMA: reg_q <= dma_data;
                default:  reg_q <= reg_q;
            endcase
        end
    end

    // Transmit shifter: reload at a boundary, otherwise shift toward the MSB.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shift_q <= '0;
        end else if (boundary) begin
            shift_q <= reg_q;
        end else if (ser_en) begin
            shift_q <= {shift_q[DATA_W-2:0], 1'b0};
        end
    end

    // The serial pin always shows the shifter MSB.
    assign ser_out = shift_q[DATA_W-1];

endmodule

// File: rtl/sdma_rx_path.sv
// Receive side: the hidden receive shifter and the bus-visible receive
// register. Bits enter at bit 0 and move upward, one per serial enable.
// On an enabled frame edge the register captures the complete word,
// including the bit arriving on that edge. A capture beats a
// programmed-I/O write on the same edge. Nothing here depends on a DMA
// enable. Assumes synchronous active-low reset and DATA_W >= 2.
module sdma_rx_path
    import sdma_pkg::*;
#(
    parameter int DATA_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_en,
    input  logic              frame,
    input  logic              ser_in,
    input  logic              pio_wr,
    input  logic [DATA_W-1:0] pio_data,
    output logic [DATA_W-1:0] reg_q
);

    rxld_e             ld_sel;
    logic [DATA_W-1:0] shift_q;
    logic [DATA_W-1:0] shift_nx;

    // Shifter contents once the incoming bit has been taken.
    assign shift_nx = {shift_q[DATA_W-2:0], ser_in};

    // Select the receive register source; a frame capture has priority.
    always_comb begin
        if (ser_en && frame)
            ld_sel = RXLD_FRAME;
        else if (pio_wr)
            ld_sel = RXLD_PIO;
        else
            ld_sel = RXLD_HOLD;
    end

    // Receive shifter: take one bit per serial enable.
    always_ff @(posedge clk) begin
        if (!rst_n)
            shift_q <= '0;
        else if (ser_en)
            shift_q <= shift_nx;
    end

    // Receive register update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_q <= '0;
        end else begin
            case (ld_sel)
                RXLD_FRAME: reg_q <= shift_nx;
                RXLD_PIO:   reg_q <= pio_data;
                default:    reg_q <= reg_q;
            endcase
        end
    end

endmodule

// File: rtl/sdma_data_port.sv
// Top of the serial DMA data port. Drops the upper bus byte on every
// write, joins the transmit and receive paths, and zero-pads both
// registers back to bus width for reads. Assumes BUS_W > DATA_W and a
// single clock with synchronous active-low reset.
module sdma_data_port
    import sdma_pkg::*;
#(
    parameter int BUS_W  = SDMA_BUS_W,
    parameter int DATA_W = SDMA_WORD_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ser_en,
    input  logic             frame,
    input  logic             ser_rx,
    output logic             ser_tx,
    input  logic             tx_dma_en,
    input  logic             dma_wr_valid,
    input  logic [BUS_W-1:0] dma_wr_data,
    input  logic             pio_wr_tx,
    input  logic             pio_wr_rx,
    input  logic [BUS_W-1:0] pio_wr_data,
    output logic [BUS_W-1:0] tx_rd_data,
    output logic [BUS_W-1:0] rx_rd_data
);

    logic [DATA_W-1:0] dma_word;
    logic [DATA_W-1:0] pio_word;
    logic [DATA_W-1:0] tx_word;
    logic [DATA_W-1:0] rx_word;
    logic              unused_hi_bits;

    // Keep only the data lanes of each write; the upper byte is discarded.
    assign dma_word       = dma_wr_data[DATA_W-1:0];
    assign pio_word       = pio_wr_data[DATA_W-1:0];
    assign unused_hi_bits = ^{dma_wr_data[BUS_W-1:DATA_W], pio_wr_data[BUS_W-1:DATA_W]};

    // Transmit register and shifter.
    sdma_tx_path #(.DATA_W(DATA_W)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .ser_en    (ser_en),
        .frame     (frame),
        .dma_en    (tx_dma_en),
        .dma_valid (dma_wr_valid),
        .dma_data  (dma_word),
        .pio_wr    (pio_wr_tx),
        .pio_data  (pio_word),
        .reg_q     (tx_word),
        .ser_out   (ser_tx)
    );

    // Receive shifter and register.
    sdma_rx_path #(.DATA_W(DATA_W)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .ser_en   (ser_en),
        .frame    (frame),
        .ser_in   (ser_rx),
        .pio_wr   (pio_wr_rx),
        .pio_data (pio_word),
        .reg_q    (rx_word)
    );

    // Zero-pad the transmit register for bus reads.
    sdma_bus_pad #(.BUS_W(BUS_W), .DATA_W(DATA_W)) u_tx_pad (
        .word_in (tx_word),
        .bus_out (tx_rd_data)
    );

    // Zero-pad the receive register for bus reads.
    sdma_bus_pad #(.BUS_W(BUS_W), .DATA_W(DATA_W)) u_rx_pad (
        .word_in (rx_word),
        .bus_out (rx_rd_data)
    );

endmodule

// File: rtl/sdma_data_port_chk.sv
// Port-level assertion checker for sdma_data_port, bound to every
// instance of it. Observes ports only and drives nothing.
module sdma_data_port_chk #(
    parameter int BUS_W  = 32,
    parameter int DATA_W = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ser_en,
    input logic             frame,
    input logic             ser_rx,
    input logic             ser_tx,
    input logic             tx_dma_en,
    input logic             dma_wr_valid,
    input logic [BUS_W-1:0] dma_wr_data,
    input logic             pio_wr_tx,
    input logic             pio_wr_rx,
    input logic [BUS_W-1:0] pio_wr_data,
    input logic [BUS_W-1:0] tx_rd_data,
    input logic [BUS_W-1:0] rx_rd_data
);

    logic unused_chk;
    assign unused_chk = ^{dma_wr_data[BUS_W-1:DATA_W], pio_wr_data[BUS_W-1:DATA_W]};

    // R1: a reset edge leaves every visible value at zero.
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (tx_rd_data == '0 && rx_rd_data == '0 && ser_tx == 1'b0));

    // R2: the upper lanes of both read values are zero.
    assert_rd_pad_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((tx_rd_data >> DATA_W) == '0) && ((rx_rd_data >> DATA_W) == '0));

    // R3: a programmed-I/O write to the transmit register keeps the low lanes.
    assert_pio_keep_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pio_wr_tx |=> tx_rd_data[DATA_W-1:0] == $past(pio_wr_data[DATA_W-1:0]));

    // R4: a DMA write with DMA disabled and no PIO write changes nothing.
    assert_dma_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_wr_valid && !tx_dma_en && !pio_wr_tx) |=> $stable(tx_rd_data));

    // R4: an enabled DMA write without PIO lands in the register.
    assert_dma_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_wr_valid && tx_dma_en && !pio_wr_tx) |=>
            tx_rd_data[DATA_W-1:0] == $past(dma_wr_data[DATA_W-1:0]));

    // R5: after a boundary the serial pin shows the old register MSB.
    assert_tx_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_en && frame) |=> ser_tx == $past(tx_rd_data[DATA_W-1]));

    // R6: without a serial enable the serial pin holds.
    assert_tx_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !ser_en |=> $stable(ser_tx));

    // R8: a capture puts the bit arriving on that edge into bit 0.
    assert_rx_capture_lsb_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_en && frame) |=> rx_rd_data[0] == $past(ser_rx));

    // R10: frame without serial enable and no PIO write leaves the receive register.
    assert_frame_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (frame && !ser_en && !pio_wr_rx) |=> $stable(rx_rd_data));

endmodule

bind sdma_data_port sdma_data_port_chk #(.BUS_W(BUS_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/test_sdma_data_port.sv
// Self-checking bench for sdma_data_port at its default 32/24 widths.
// A per-cycle reference model built from the requirements checks every
// step; targeted sweeps add arithmetic checks on specific behaviours.
module test_sdma_data_port;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ser_en = 1'b0;
    logic        frame = 1'b0;
    logic        ser_rx = 1'b0;
    logic        ser_tx;
    logic        tx_dma_en = 1'b0;
    logic        dma_wr_valid = 1'b0;
    logic [31:0] dma_wr_data = '0;
    logic        pio_wr_tx = 1'b0;
    logic        pio_wr_rx = 1'b0;
    logic [31:0] pio_wr_data = '0;
    logic [31:0] tx_rd_data;
    logic [31:0] rx_rd_data;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // reference model state
    logic [23:0] m_txr = '0, m_txs = '0, m_rxs = '0, m_rxr = '0;

    always #2 clk = ~clk;   // 250 MHz

    sdma_data_port i_sdma_data_port (.*);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One clock cycle with the given inputs; updates the model and compares.
    task automatic step(input logic en, input logic fr, input logic rb,
                        input logic dv, input logic [31:0] dd,
                        input logic ptx, input logic prx, input logic [31:0] pd);
        logic [23:0] n_txr, n_txs, n_rxs, n_rxr;
        ser_en = en; frame = fr; ser_rx = rb;
        dma_wr_valid = dv; dma_wr_data = dd;
        pio_wr_tx = ptx; pio_wr_rx = prx; pio_wr_data = pd;
        n_txr = ptx ? pd[23:0] : ((dv && tx_dma_en) ? dd[23:0] : m_txr);
        n_txs = (en && fr) ? m_txr : (en ? (m_txs << 1) : m_txs);
        n_rxs = en ? {m_rxs[22:0], rb} : m_rxs;
        n_rxr = (en && fr) ? {m_rxs[22:0], rb} : (prx ? pd[23:0] : m_rxr);
        @(posedge clk); #1;
        m_txr = n_txr; m_txs = n_txs; m_rxs = n_rxs; m_rxr = n_rxr;
        check("R4/R3 tx register", tx_rd_data, {8'h00, m_txr});
        check("R8/R9 rx register", rx_rd_data, {8'h00, m_rxr});
        check("R6/R5 serial out", {31'b0, ser_tx}, {31'b0, m_txs[23]});
        ser_en = 1'b0; frame = 1'b0; dma_wr_valid = 1'b0; pio_wr_tx = 1'b0; pio_wr_rx = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        @(posedge clk); #1;
        rst_n = 1'b1;
        m_txr = '0; m_txs = '0; m_rxs = '0; m_rxr = '0;
        // R1: everything visible is zero after reset
        check("R1 tx after reset", tx_rd_data, 32'h0);
        check("R1 rx after reset", rx_rd_data, 32'h0);
        check("R1 ser_tx after reset", {31'b0, ser_tx}, 32'h0);
    endtask

    initial begin : watchdog
        #(4 * 200000);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin : stim
        logic [23:0] w;
        logic [31:0] exp;
        logic [23:0] words [4];
        @(posedge clk); #1;
        do_reset();

        // R2, R3: every upper-byte value is dropped on both registers
        for (int b = 0; b < 256; b++) begin
            w = 24'h5A0000 ^ 24'(b * 24'h010203);
            step(0, 0, 0, 0, '0, 1, 1, {b[7:0], w});
            check("R3 tx low lanes", tx_rd_data, {8'h00, w});
            check("R2 rx upper byte", {24'b0, rx_rd_data[31:24]}, 32'h0);
        end

        // R4: all combinations of PIO write, DMA strobe and DMA enable
        for (int c = 0; c < 8; c++) begin
            step(0, 0, 0, 0, '0, 1, 0, 32'h00C0FFEE);
            tx_dma_en = c[0];
            step(0, 0, 0, c[1], 32'hFF123456, c[2], 0, 32'hAB654321);
            exp = c[2] ? 32'h00654321 : ((c[1] && c[0]) ? 32'h00123456 : 32'h00C0FFEE);
            check("R4 dma gating / pio priority", tx_rd_data, exp);
        end
        tx_dma_en = 1'b0;

        // R5, R6: serialisation MSB first, with idle cycles between bits, DMA disabled
        w = 24'hA5C3E1;
        step(0, 0, 0, 0, '0, 1, 0, {8'h00, w});
        step(1, 1, 0, 0, '0, 0, 0, '0);
        for (int i = 0; i < 24; i++) begin
            check("R5/R6 tx bit order", {31'b0, ser_tx}, {31'b0, w[23-i]});
            step(0, 0, 0, 0, '0, 0, 0, '0);
            check("R6 hold without enable", {31'b0, ser_tx}, {31'b0, w[23-i]});
            step(1, 0, 0, 0, '0, 0, 0, '0);
        end
        check("R6 zero fill", {31'b0, ser_tx}, 32'h0);

        // R7, R8: shift in a known pattern, capture at the 24th bit
        w = 24'h3C96F0;
        for (int i = 0; i < 24; i++)
            step(1, (i == 23), w[23-i], 0, '0, 0, 0, '0);
        check("R7/R8 rx capture", rx_rd_data, {8'h00, w});

        // R7, R8, R5: loopback of several words
        words[0] = 24'h000001; words[1] = 24'h800000;
        words[2] = 24'hFFFFFF; words[3] = 24'h123ABC;
        step(0, 0, 0, 0, '0, 1, 0, {8'hEE, words[0]});
        step(1, 1, ser_tx, 0, '0, 0, 0, '0);
        for (int k = 0; k < 4; k++) begin
            for (int i = 0; i < 23; i++)
                step(1, 0, ser_tx, 0, '0, 0, 0, '0);
            step(0, 0, 0, 0, '0, 1, 0, {8'h77, words[(k + 1) % 4]});
            step(1, 1, ser_tx, 0, '0, 0, 0, '0);
            check("R8 loopback word", rx_rd_data, {8'h00, words[k]});
        end

        // R9: capture beats a same-edge PIO write to the receive register
        step(1, 1, 1, 0, '0, 0, 1, 32'h00ABCDEF);
        check("R9 capture priority", {31'b0, rx_rd_data[0]}, 32'h1);
        step(0, 0, 0, 0, '0, 0, 1, 32'h11ABCDEF);
        check("R3 rx pio write", rx_rd_data, 32'h00ABCDEF);

        // R10: frame without serial enable changes nothing
        step(0, 0, 0, 0, '0, 1, 0, 32'h00F0F0F0);
        for (int i = 0; i < 4; i++)
            step(0, 1, i[0], 0, '0, 0, 0, '0);
        check("R10 rx unaffected", rx_rd_data, 32'h00ABCDEF);

        // R1: reset in mid-run
        step(1, 0, 1, 0, '0, 1, 1, 32'h00FFFFFF);
        do_reset();
        step(1, 1, 0, 0, '0, 0, 0, '0);
        check("R1 shifters cleared", {31'b0, ser_tx}, 32'h0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule